// File: doc/BRIEF.md
# Activity-Monitor Read Trap Decision Unit

This block holds a 64-bit trap-control word that the hypervisor writes. For every read of an activity-monitor register it decides whether that read is sent to privilege level 2. The registers covered are the event counters, the event-type selectors and the counter-enable set/clear pair, in both the fixed group (group 0) and the auxiliary group (group 1). An access request supplies three things about the target register: its group, its index and its kind. It also supplies the privilege level and execution width of the issuing code, a set of virtualization conditions and a flag that marks a higher-priority exception.

The unit finds the control bit for the target and gates it with the virtualization conditions. It then returns a registered trap flag and an exception-class code. Instruction decode, the counters themselves and exception entry belong to neighbouring blocks.

Top module: `amon_read_trap`

## Requirements
- R1: After a synchronous active-high reset the control word reads all zeros, and no read produces a trap.
- R2: A write stores only the defined control bits. Bits 0 to 4 and 17 to 49 are defined. Bits 5 to 16 and 50 to 63 always read back as zero, whatever was written.
- R3: Kind encoding is 0 = counter, 1 = event type, 2 = enable set/clear, 3 = none. In group 1 (req_group = 1), event-type register x (0 to 15) is governed by bit 19+2x and counter x by bit 18+2x.
- R4: In group 0, counter x for x = 0 to 3 is governed by bit x+1. Group-0 counters with index 4 or more, group-0 event-type reads and kind 3 reads never trap.
- R5: Enable set/clear reads are governed by bit 0 for group 0 and by bit 17 for group 1, whatever the index.
- R6: A read traps only when all of these hold: its control bit is 1, level 2 is present, level 2 is enabled, the host/general-trap pair is not both 1, level 1 runs 64-bit code, and level 3 is absent or its fine-grained enable is 1.
- R7: Reads issued at level 2 or level 3 (req_el = 2 or 3) never trap.
- R8: 32-bit reads (req_a32 = 1) can trap only at level 0. A 32-bit read at level 1 never traps.
- R9: A trapped 64-bit read reports class 0x18. A trapped 32-bit read at level 0 reports class 0x03. When there is no trap the class output is 0.
- R10: When hi_pri_exc is set with the request, the trap is suppressed.
- R11: rsp_valid, trap and ec_class appear exactly one cycle after req_valid. The decision uses the control word as it was before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | New control word value |
| ctl_word | output | 64 | Current control word (reserved bits zero) |
| req_valid | input | 1 | Read access request |
| req_group | input | 1 | 0 = fixed group, 1 = auxiliary group |
| req_index | input | 4 | Register index within the group |
| req_kind | input | 2 | 0 counter, 1 event type, 2 enable set/clear, 3 none |
| req_el | input | 2 | Privilege level of the access |
| req_a32 | input | 1 | 1 = 32-bit execution |
| el2_present | input | 1 | Level 2 implemented |
| el2_enabled | input | 1 | Level 2 enabled in current security state |
| hv_host | input | 1 | Hypervisor host-mode bit |
| hv_tge | input | 1 | Hypervisor general-trap bit |
| el1_a64 | input | 1 | Level 1 runs 64-bit code |
| el3_present | input | 1 | Level 3 implemented |
| el3_fine_en | input | 1 | Level-3 fine-grained trap enable |
| hi_pri_exc | input | 1 | Access already raises a higher-priority exception |
| rsp_valid | output | 1 | Decision valid |
| trap | output | 1 | Read is trapped to level 2 |
| ec_class | output | 6 | Exception class code for the trap |

## Verification
A write to the control word and a read decision can land in the same cycle. The decision must then use the old word, and the new word takes effect only for later reads. The bench provokes this in two ways. It clears a fully set word while it issues a read that the old word traps. It also sets a single bit while it issues a read of that bit. Each same-cycle result is compared against a model that applies the write only after it has predicted that read, and a follow-up read confirms the new value.

// File: rtl/amon_trap_pkg.sv
`timescale 1ns/1ps
package amon_trap_pkg;

  typedef enum logic [1:0] {
    KIND_CNT  = 2'd0,
    KIND_TYPE = 2'd1,
    KIND_EN   = 2'd2,
    KIND_NONE = 2'd3
  } acc_kind_e;

  localparam logic [5:0] EC_WIDE   = 6'h18;
  localparam logic [5:0] EC_NARROW = 6'h03;

endpackage

// File: rtl/amon_ctl_reg.sv
`timescale 1ns/1ps
module amon_ctl_reg #(
  parameter int W       = 64,
  parameter int G0_EN   = 0,
  parameter int G0_BASE = 1,
  parameter int NUM_G0  = 4,
  parameter int G1_EN   = 17,
  parameter int G1_BASE = 18,
  parameter int NUM_G1  = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] legal_bits();
    logic [W-1:0] m;
    m = '0;
    m[G0_EN] = 1'b1;
    m[G1_EN] = 1'b1;
    for (int i = 0; i < NUM_G0; i++) m[G0_BASE + i] = 1'b1;
    for (int i = 0; i < 2 * NUM_G1; i++) m[G1_BASE + i] = 1'b1;
    return m;
  endfunction

  localparam logic [W-1:0] MASK = legal_bits();

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data & MASK;
  end

  // R2: without a write strobe the stored word does not move
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/amon_bit_sel.sv
`timescale 1ns/1ps
module amon_bit_sel
  import amon_trap_pkg::*;
#(
  parameter int W       = 64,
  parameter int IDX_W   = 4,
  parameter int G0_EN   = 0,
  parameter int G0_BASE = 1,
  parameter int NUM_G0  = 4,
  parameter int G1_EN   = 17,
  parameter int G1_BASE = 18,
  parameter int NUM_G1  = 16,
  localparam int POS_W  = $clog2(W)
) (
  input  logic             group,
  input  logic [IDX_W-1:0] index,
  input  logic [1:0]       kind,
  output logic             has_bit,
  output logic [POS_W-1:0] bit_pos
);

  acc_kind_e k;
  int        idx;

  always_comb begin
    k       = acc_kind_e'(kind);
    idx     = int'(index);
    has_bit = 1'b0;
    bit_pos = '0;
    unique case (k)
      KIND_EN: begin
        has_bit = 1'b1;
        bit_pos = group ? POS_W'(G1_EN) : POS_W'(G0_EN);
      end
      KIND_CNT: begin
        if (group) begin
          has_bit = (idx < NUM_G1);
          bit_pos = POS_W'(G1_BASE + 2 * idx);
        end else begin
          has_bit = (idx < NUM_G0);
          bit_pos = POS_W'(G0_BASE + idx);
        end
      end
      KIND_TYPE: begin
        if (group) begin
          has_bit = (idx < NUM_G1);
          bit_pos = POS_W'(G1_BASE + 1 + 2 * idx);
        end
      end
      default: begin
        has_bit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/amon_gate.sv
`timescale 1ns/1ps
module amon_gate
  import amon_trap_pkg::*;
(
  input  logic [1:0] el,
  input  logic       a32,
  input  logic       el2_present,
  input  logic       el2_enabled,
  input  logic       hv_host,
  input  logic       hv_tge,
  input  logic       el1_a64,
  input  logic       el3_present,
  input  logic       el3_fine_en,
  input  logic       hi_pri_exc,
  output logic       allow,
  output logic [5:0] ec
);

  logic level_ok;
  logic virt_ok;

  always_comb begin
    level_ok = a32 ? (el == 2'd0) : (el <= 2'd1);
    virt_ok  = el2_present && el2_enabled && !(hv_host && hv_tge) &&
               el1_a64 && (!el3_present || el3_fine_en);
    allow    = level_ok && virt_ok && !hi_pri_exc;
    ec       = a32 ? EC_NARROW : EC_WIDE;
  end

endmodule

// File: rtl/amon_read_trap.sv
`timescale 1ns/1ps
module amon_read_trap
  import amon_trap_pkg::*;
#(
  parameter int W       = 64,
  parameter int IDX_W   = 4,
  parameter int G0_EN   = 0,
  parameter int G0_BASE = 1,
  parameter int NUM_G0  = 4,
  parameter int G1_EN   = 17,
  parameter int G1_BASE = 18,
  parameter int NUM_G1  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     ctl_word,
  input  logic             req_valid,
  input  logic             req_group,
  input  logic [IDX_W-1:0] req_index,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_el,
  input  logic             req_a32,
  input  logic             el2_present,
  input  logic             el2_enabled,
  input  logic             hv_host,
  input  logic             hv_tge,
  input  logic             el1_a64,
  input  logic             el3_present,
  input  logic             el3_fine_en,
  input  logic             hi_pri_exc,
  output logic             rsp_valid,
  output logic             trap,
  output logic [5:0]       ec_class
);

  localparam int POS_W = $clog2(W);

  logic             has_bit;
  logic [POS_W-1:0] bit_pos;
  logic             allow;
  logic [5:0]       ec;
  logic             hit;

  amon_ctl_reg #(
    .W(W), .G0_EN(G0_EN), .G0_BASE(G0_BASE), .NUM_G0(NUM_G0),
    .G1_EN(G1_EN), .G1_BASE(G1_BASE), .NUM_G1(NUM_G1)
  ) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .q(ctl_word)
  );

  amon_bit_sel #(
    .W(W), .IDX_W(IDX_W), .G0_EN(G0_EN), .G0_BASE(G0_BASE), .NUM_G0(NUM_G0),
    .G1_EN(G1_EN), .G1_BASE(G1_BASE), .NUM_G1(NUM_G1)
  ) u_sel (
    .group(req_group), .index(req_index), .kind(req_kind),
    .has_bit(has_bit), .bit_pos(bit_pos)
  );

  amon_gate u_gate (
    .el(req_el), .a32(req_a32),
    .el2_present(el2_present), .el2_enabled(el2_enabled),
    .hv_host(hv_host), .hv_tge(hv_tge), .el1_a64(el1_a64),
    .el3_present(el3_present), .el3_fine_en(el3_fine_en),
    .hi_pri_exc(hi_pri_exc), .allow(allow), .ec(ec)
  );

  assign hit = req_valid && has_bit && ctl_word[bit_pos] && allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      trap      <= 1'b0;
      ec_class  <= '0;
    end else begin
      rsp_valid <= req_valid;
      trap      <= hit;
      ec_class  <= hit ? ec : 6'd0;
    end
  end

  // R9: a trap always carries one of the two legal classes
  a_r9_class_on_trap: assert property (@(posedge clk) disable iff (rst)
    trap |-> (ec_class == EC_WIDE || ec_class == EC_NARROW));

  // R9: the class is zero whenever there is no trap
  a_r9_class_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !trap |-> ec_class == 6'd0);

  // R10: a higher-priority exception suppresses the trap
  a_r10_hipri_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && hi_pri_exc) |-> !trap);

  // R7: level 2 and level 3 reads never trap
  a_r7_upper_levels: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_el[1]) |-> !trap);

  // R8: 32-bit reads at level 1 never trap
  a_r8_narrow_el1: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_a32 && req_el == 2'd1) |-> !trap);

  // R11: a response follows each request one cycle later
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && !$past(rst)) |-> rsp_valid);

endmodule

// File: tb/tb_amon_read_trap.sv
`timescale 1ns/1ps
module tb_amon_read_trap;

  localparam logic [63:0] LEGAL = 64'h0003_FFFF_FFFE_001F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] ctl_word;
  logic        req_valid = 1'b0;
  logic        req_group = 1'b0;
  logic [3:0]  req_index = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_el = '0;
  logic        req_a32 = 1'b0;
  logic        el2_present = 1'b1, el2_enabled = 1'b1;
  logic        hv_host = 1'b0, hv_tge = 1'b0, el1_a64 = 1'b1;
  logic        el3_present = 1'b1, el3_fine_en = 1'b1, hi_pri_exc = 1'b0;
  logic        rsp_valid, trap;
  logic [5:0]  ec_class;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] model = '0;

  typedef struct {
    logic       trap;
    logic [5:0] ec;
    string      tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  amon_read_trap dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctl_word(ctl_word),
    .req_valid(req_valid), .req_group(req_group), .req_index(req_index),
    .req_kind(req_kind), .req_el(req_el), .req_a32(req_a32),
    .el2_present(el2_present), .el2_enabled(el2_enabled),
    .hv_host(hv_host), .hv_tge(hv_tge), .el1_a64(el1_a64),
    .el3_present(el3_present), .el3_fine_en(el3_fine_en),
    .hi_pri_exc(hi_pri_exc), .rsp_valid(rsp_valid), .trap(trap),
    .ec_class(ec_class)
  );

  function automatic int ctl_pos(bit g, int idx, int kind);
    if (kind == 2) return g ? 17 : 0;
    if (g && kind == 0) return 18 + 2 * idx;
    if (g && kind == 1) return 19 + 2 * idx;
    if (!g && kind == 0 && idx < 4) return idx + 1;
    return -1;
  endfunction

  function automatic item_t predict(string tag);
    item_t it;
    int    p;
    bit    ok;
    p  = ctl_pos(req_group, int'(req_index), int'(req_kind));
    ok = (p >= 0) && model[p] && el2_present && el2_enabled &&
         !(hv_host && hv_tge) && el1_a64 && (!el3_present || el3_fine_en) &&
         !hi_pri_exc && (req_a32 ? (req_el == 0) : (req_el <= 1));
    it.trap = ok;
    it.ec   = ok ? (req_a32 ? 6'h03 : 6'h18) : 6'h00;
    it.tag  = tag;
    return it;
  endfunction

  task automatic env_default();
    el2_present = 1; el2_enabled = 1; hv_host = 0; hv_tge = 0;
    el1_a64 = 1; el3_present = 1; el3_fine_en = 1; hi_pri_exc = 0;
    req_el = 0; req_a32 = 0;
  endtask

  // Drive one read; the caller may also raise wr_en for the same cycle
  task automatic rd(bit g, int idx, int kind, string tag);
    req_group = g;
    req_index = 4'(idx);
    req_kind  = 2'(kind);
    req_valid = 1'b1;
    sb.push_back(predict(tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [63:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model = d & LEGAL;
  endtask

  task automatic chk_word(logic [63:0] exp, string tag);
    n_tests++;
    if (ctl_word !== exp) begin
      n_fail++;
      $display("FAIL %s: ctl_word actual %h expected %h", tag, ctl_word, exp);
    end
  endtask

  // Monitor: compare each response against the scoreboard head
  always @(posedge clk) begin
    #2;
    if (!rst && rsp_valid) begin
      item_t e;
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R11: unexpected response actual trap %b expected none", trap);
      end else begin
        e = sb.pop_front();
        if (trap !== e.trap || ec_class !== e.ec) begin
          n_fail++;
          $display("FAIL %s: actual trap %b ec %h expected trap %b ec %h",
                   e.tag, trap, ec_class, e.trap, e.ec);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_word(64'h0, "R1");
    rd(1, 3, 0, "R1");
    rd(0, 0, 2, "R1");

    wr('1);
    chk_word(LEGAL, "R2");
    wr(64'h0000_0000_0001_FFE0 | 64'hFFFC_0000_0000_0000);
    chk_word(64'h0, "R2");

    wr('1);
    for (int i = 0; i < 16; i++) begin
      rd(1, i, 0, "R3");
      rd(1, i, 1, "R3");
    end
    wr(64'h1 << (19 + 2 * 5));
    rd(1, 5, 1, "R3");
    rd(1, 5, 0, "R3");
    rd(1, 4, 1, "R3");
    wr(64'h1 << 48);
    rd(1, 15, 0, "R3");
    rd(1, 15, 1, "R3");

    wr('1);
    for (int i = 0; i < 8; i++) rd(0, i, 0, "R4");
    rd(0, 2, 1, "R4");
    rd(1, 2, 3, "R4");
    wr(64'h1 << 3);
    rd(0, 2, 0, "R4");
    rd(0, 1, 0, "R4");

    wr(64'h1);
    rd(0, 9, 2, "R5");
    rd(1, 0, 2, "R5");
    wr(64'h1 << 17);
    rd(1, 6, 2, "R5");
    rd(0, 0, 2, "R5");

    wr('1);
    el2_present = 0; rd(1, 1, 0, "R6"); env_default();
    el2_enabled = 0; rd(1, 1, 0, "R6"); env_default();
    hv_host = 1; hv_tge = 1; rd(1, 1, 0, "R6"); env_default();
    hv_host = 1; rd(1, 1, 0, "R6"); env_default();
    hv_tge = 1; rd(1, 1, 0, "R6"); env_default();
    el1_a64 = 0; rd(1, 1, 0, "R6"); env_default();
    el3_fine_en = 0; rd(1, 1, 0, "R6"); env_default();
    el3_present = 0; el3_fine_en = 0; rd(1, 1, 0, "R6"); env_default();

    req_el = 2; rd(1, 2, 1, "R7");
    req_el = 3; rd(0, 0, 0, "R7");
    req_el = 1; rd(0, 0, 0, "R7");
    env_default();

    req_a32 = 1; req_el = 1; rd(1, 7, 0, "R8");
    req_el = 0; rd(1, 7, 0, "R9");
    env_default();
    rd(1, 7, 0, "R9");

    hi_pri_exc = 1; rd(0, 0, 2, "R10");
    req_a32 = 1; rd(1, 0, 1, "R10");
    env_default();

    // R11: write and read in one cycle; the read sees the old word
    wr_en = 1'b1; wr_data = '0;
    rd(1, 3, 1, "R11");
    wr_en = 1'b0; model = '0;
    rd(1, 3, 1, "R11");
    wr_en = 1'b1; wr_data = 64'h1 << 2;
    rd(0, 1, 0, "R11");
    wr_en = 1'b0; model = 64'h1 << 2;
    rd(0, 1, 0, "R11");

    repeat (3) @(negedge clk);
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11: pending responses actual %0d expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule